// File: doc/BRIEF.md
# Watchdog timer with prescaler

This block resets the system when software stops servicing it. It runs from the oscillator clock. A free-running binary prescaler drives a small overflow counter. A rate input chooses which prescaler tap advances that counter, and so picks a short or a long timeout.

Software services the timer by writing to one fixed bus address. The data value of the write does not matter. A service write clears the counter and the upper prescaler stages. The lowest prescaler stages keep running, so the time to the next timeout varies slightly with the phase of the write.

When the counter overflows, the block drives its active-low reset output for a fixed number of cycles. It also latches a cause flag, which only an explicit clear or the block's own reset removes. A stop-entry pulse clears the whole prescaler. A high-voltage disable input freezes the timing chain and suppresses overflow.

Top module: `wdog_timer`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it rises, `rst_no` is 1 and `cause_o` is 0.
- R2: With `rate_long_i`=1 the timeout length T is 2^(PRESC_W+CNT_W). After reset release with no further stimulus, the overflow happens on clock edge T, counted from the release. `rst_no` is first seen low after that edge.
- R3: With `rate_long_i`=0 the counter advances from the carry out of prescaler bit SHORT_TAP-1. The timeout length is therefore T = 2^(SHORT_TAP+CNT_W), with the same counting as in R2.
- R4: A service write is a cycle with `bus_we_i`=1 and `bus_addr_i`=SVC_ADDR. It clears the counter and prescaler bits KEEP_LO and above. Bits 0..KEEP_LO-1 keep counting. For a service write on edge j (with no earlier clear since reset), overflow therefore falls on edge j + T − (j mod 2^KEEP_LO).
- R5: A bus write to any other address has no effect on the timing.
- R6: Each overflow holds `rst_no` low for exactly RST_LEN cycles. The chain is held cleared during the pulse, so the next overflow falls T edges after the edge that releases the pulse.
- R7: `cause_o` is set in the same cycle that `rst_no` falls, and it stays set through and after the pulse. A one-cycle `flag_clr_i` clears it. If a set and a clear fall on the same edge, the set wins.
- R8: A `stop_i` pulse on edge s clears the whole prescaler but keeps the counter. Overflow then falls on edge s + T − C. C is the count reached before edge s, truncated to a multiple of 2^tap, where tap is PRESC_W for the long setting and SHORT_TAP for the short setting.
- R9: While `hv_dis_i` is 1, the chain does not count and no reset pulse starts. Holding it for D cycles from reset release delays the overflow to edge T + D.
- R10: A service write on the very edge where the overflow would occur prevents the reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| bus_we_i | input | 1 | Bus write strobe |
| bus_addr_i | input | ADDR_W | Bus write address |
| rate_long_i | input | 1 | 1 selects the long timeout, 0 the short timeout |
| stop_i | input | 1 | Stop-entry pulse, clears the prescaler |
| hv_dis_i | input | 1 | High-voltage disable condition |
| flag_clr_i | input | 1 | Clears the reset-cause flag |
| rst_no | output | 1 | Active-low reset request |
| cause_o | output | 1 | Sticky flag: this block caused a reset |

## Verification
The bench builds the block with PRESC_W=6, CNT_W=3, KEEP_LO=2, SHORT_TAP=4 and RST_LEN=5. These values give timeouts of 128 and 512 cycles. That makes it possible to place a service write on every edge of a complete short-mode period, including the edge of overflow itself. The same values also make it practical to cover the opening and closing edges of a long-mode period, and to measure a pulse followed by the next full timeout. The bench computes every expected overflow edge from the R4 and R8 formulas. It also checks the stop, disable and cause-flag cases on these short chains.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic {
    RATE_SHORT = 1'b0,
    RATE_LONG  = 1'b1
  } rate_e;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int W         = 12,
  parameter int KEEP_LO   = 4,
  parameter int SHORT_TAP = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_all_i,
  input  logic clr_hi_i,
  input  logic rate_long_i,
  output logic tick_o
);
  localparam int HI_W = W - KEEP_LO;

  logic [W-1:0]       q_q, q_d;
  logic [KEEP_LO-1:0] lo_next;
  logic               tick_short, tick_long;
  wdog_pkg::rate_e    rate;

  assign rate    = wdog_pkg::rate_e'(rate_long_i);
  assign lo_next = q_q[KEEP_LO-1:0] + KEEP_LO'(en_i);

  always_comb begin
    if (clr_all_i)     q_d = '0;
    else if (clr_hi_i) q_d = {{HI_W{1'b0}}, lo_next};
    else if (en_i)     q_d = q_q + W'(1);
    else               q_d = q_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  // a stop clears the stage that would have carried
  assign tick_short = en_i & ~clr_all_i & (&q_q[SHORT_TAP-1:0]);
  assign tick_long  = en_i & ~clr_all_i & (&q_q);
  assign tick_o     = (rate == wdog_pkg::RATE_LONG) ? tick_long : tick_short;
endmodule

// File: rtl/wdog_ovf_counter.sv
module wdog_ovf_counter #(
  parameter int W = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic wrap_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '0;
    else if (clr_i)  q_q <= '0;
    else if (tick_i) q_q <= q_q + W'(1);
  end

  assign wrap_o = tick_i & (&q_q);
endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
  parameter int LEN = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q;
  logic          active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i && !active_q) begin
      active_q <= 1'b1;
      cnt_q    <= CW'(LEN - 1);
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - CW'(1);
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR  = '1,
  parameter int                PRESC_W   = 12,
  parameter int                CNT_W     = 6,
  parameter int                KEEP_LO   = 4,
  parameter int                SHORT_TAP = 7,
  parameter int                RST_LEN   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              rate_long_i,
  input  logic              stop_i,
  input  logic              hv_dis_i,
  input  logic              flag_clr_i,
  output logic              rst_no,
  output logic              cause_o
);
  logic svc, en, tick, wrap, ovf, active, cause_q;

  assign svc = bus_we_i & (bus_addr_i == SVC_ADDR);
  assign en  = ~hv_dis_i & ~active;

  wdog_prescaler #(
    .W         (PRESC_W),
    .KEEP_LO   (KEEP_LO),
    .SHORT_TAP (SHORT_TAP)
  ) i_presc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .clr_all_i   (stop_i | active),
    .clr_hi_i    (svc),
    .rate_long_i (rate_long_i),
    .tick_o      (tick)
  );

  wdog_ovf_counter #(
    .W (CNT_W)
  ) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .clr_i  (svc | active),
    .wrap_o (wrap)
  );

  // service in the overflow cycle wins
  assign ovf = wrap & ~svc;

  wdog_rst_pulse #(
    .LEN (RST_LEN)
  ) i_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (ovf),
    .active_o (active)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cause_q <= 1'b0;
    else if (ovf)        cause_q <= 1'b1;
    else if (flag_clr_i) cause_q <= 1'b0;
  end

  assign rst_no  = ~active;
  assign cause_o = cause_q;
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR = '1,
  parameter int                RST_LEN  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              hv_dis_i,
  input logic              flag_clr_i,
  input logic              rst_no,
  input logic              cause_o
);
  localparam int LW = $clog2(RST_LEN + 2);

  logic [LW-1:0] low_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     low_run <= '0;
    else if (!rst_no) low_run <= low_run + LW'(1);
    else             low_run <= '0;
  end

  // R6
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> low_run == LW'(RST_LEN));

  // R6
  pulse_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_no |-> low_run < LW'(RST_LEN));

  // R7
  cause_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cause_o) |-> $fell(rst_no));

  // R7
  cause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_o && !flag_clr_i |=> cause_o);

  // R7
  cause_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr_i && rst_no |=> !cause_o || $fell(rst_no));

  // R9
  dis_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hv_dis_i && rst_no |=> rst_no);

  // R10
  svc_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i && (bus_addr_i == SVC_ADDR) && rst_no |=> rst_no);
endmodule

bind wdog_timer wdog_timer_chk #(
  .ADDR_W   (ADDR_W),
  .SVC_ADDR (SVC_ADDR),
  .RST_LEN  (RST_LEN)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .hv_dis_i   (hv_dis_i),
  .flag_clr_i (flag_clr_i),
  .rst_no     (rst_no),
  .cause_o    (cause_o)
);

// File: tb/test_wdog_timer.sv
`timescale 1ns/1ps
module test_wdog_timer;
  localparam int PW = 6, CW = 3, KL = 2, ST = 4, RL = 5, AW = 16;
  localparam int TL = 2 ** (PW + CW);
  localparam int TS = 2 ** (ST + CW);
  localparam logic [AW-1:0] SVC = 16'hFFFF;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, rate = 1'b0;
  logic stop = 1'b0, dis = 1'b0, fclr = 1'b0;
  logic [AW-1:0] addr = '0;
  wire rst_o, cause;
  int ecnt = 0, tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) ecnt <= 0;
    else        ecnt <= ecnt + 1;

  wdog_timer #(
    .ADDR_W (AW), .SVC_ADDR (SVC), .PRESC_W (PW), .CNT_W (CW),
    .KEEP_LO (KL), .SHORT_TAP (ST), .RST_LEN (RL)
  ) i_wdog_timer (
    .clk_i (clk), .rst_ni (rst_n), .bus_we_i (we), .bus_addr_i (addr),
    .rate_long_i (rate), .stop_i (stop), .hv_dis_i (dis),
    .flag_clr_i (fclr), .rst_no (rst_o), .cause_o (cause)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic r);
    @(negedge clk);
    rst_n = 1'b0; we = 1'b0; stop = 1'b0; dis = 1'b0; fclr = 1'b0;
    addr = '0; rate = r;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // returns edge index of first low sample and length of the low run
  task automatic meas(output int first, output int len);
    int guard = 0;
    while (rst_o === 1'b1 && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    first = ecnt;
    len = 0;
    while (rst_o === 1'b0 && len < 100) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic wr_at(input int j, input logic [AW-1:0] a);
    repeat (j - 1) @(negedge clk);
    we = 1'b1; addr = a;
    @(negedge clk);
    we = 1'b0; addr = '0;
  endtask

  task automatic svc_case(input logic r, input int j);
    int t, f, l, e;
    t = r ? TL : TS;
    do_reset(r);
    wr_at(j, SVC);
    meas(f, l);
    e = j + t - (j % (2 ** KL));
    if (r) check(f == e, "R2 R4 long timeout after service", f, e);
    else   check(f == e, "R3 R4 short timeout after service", f, e);
    check(l == RL, "R6 pulse length", l, RL);
  endtask

  initial begin
    int f, l, f2, e, ca;
    do_reset(1'b1);
    check(rst_o === 1'b1, "R1 reset rst_no", rst_o, 1);
    check(cause === 1'b0, "R1 reset cause", cause, 0);
    @(negedge clk);
    check(rst_o === 1'b1 && cause === 1'b0, "R1 after release", {rst_o, cause}, 2);

    // R2 R6 R7: free run, pulse, restart from zero
    do_reset(1'b1);
    meas(f, l);
    check(f == TL, "R2 first overflow edge", f, TL);
    check(l == RL, "R6 pulse length", l, RL);
    check(cause === 1'b1, "R7 cause sticky after pulse", cause, 1);
    meas(f2, l);
    check(f2 == f + RL + TL, "R6 restart from zero", f2, f + RL + TL);
    fclr = 1'b1;
    @(negedge clk);
    fclr = 1'b0;
    check(cause === 1'b0, "R7 cause cleared", cause, 0);

    // R3 free run
    do_reset(1'b0);
    meas(f, l);
    check(f == TS, "R3 short overflow edge", f, TS);

    // R3 R4 R10: every service phase in short mode
    for (int j = 1; j <= TS; j++) svc_case(1'b0, j);
    // R2 R4 R10: edges of a long period
    for (int j = 1; j <= 12; j++) svc_case(1'b1, j);
    for (int j = TL - 5; j <= TL; j++) svc_case(1'b1, j);

    // R10 explicit: service on the overflow edge
    do_reset(1'b1);
    wr_at(TL, SVC);
    check(rst_o === 1'b1, "R10 service on overflow edge", rst_o, 1);

    // R5 other address ignored
    for (int k = 0; k < 2; k++) begin
      do_reset(1'(k));
      wr_at(40, 16'hFFFE - AW'(k));
      meas(f, l);
      e = k ? TL : TS;
      check(f == e, "R5 other address ignored", f, e);
    end

    // R8 stop pulses
    for (int k = 0; k < 2; k++) begin
      int s, tap, t;
      s = k ? 200 : 100;
      tap = k ? PW : ST;
      t = k ? TL : TS;
      do_reset(1'(k));
      repeat (s - 1) @(negedge clk);
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      meas(f, l);
      ca = ((s - 1) >> tap) << tap;
      check(f == s + t - ca, "R8 stop clears prescaler", f, s + t - ca);
    end

    // R9 disable freezes the chain
    for (int k = 0; k < 2; k++) begin
      int d;
      d = k ? 150 : 37;
      do_reset(1'(k));
      dis = 1'b1;
      repeat (d) @(negedge clk);
      dis = 1'b0;
      meas(f, l);
      e = (k ? TL : TS) + d;
      check(f == e, "R9 disable delays overflow", f, e);
    end

    // R7 set wins over clear on the same edge
    do_reset(1'b0);
    repeat (TS - 1) @(negedge clk);
    fclr = 1'b1;
    @(negedge clk);
    fclr = 1'b0;
    check(cause === 1'b1, "R7 set wins over clear", cause, 1);
    check(rst_o === 1'b0, "R7 pulse on set edge", rst_o, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule